// File: doc/BRIEF.md
# Configurable Counter, Delay and Lookup Macrocell

This block is a small reconfigurable logic cell steered entirely by a static configuration word. A 2-bit function field turns it into one of four cells: an edge-selective delay line, a down-counter with a wrap pulse, an edge detector, or a 3-input lookup table. The 8-bit data field is shared. In lookup mode it is the truth table. In the counting modes it is the preload.

The cell has one system clock. Its time base is one of thirteen tick strobes brought in on a port vector and chosen by a 4-bit source field. Each strobe is a one-cycle enable that is synchronous to the system clock. Codes 13 to 15 select no source, so the count freezes. The oscillators and dividers that produce the strobes sit outside the block.

The controller is a six-state machine:
- LUT: lookup table.
- EDGE: edge detector.
- DLY_IDLE and DLY_PEND: delay line, waiting or with a transition in flight.
- CNT_RUN and CNT_HOLD: counter, running or being reset.

Transitions:
- RECONFIG: entered from any state when the function field stops matching the current state's function.
- ARM: DLY_IDLE to DLY_PEND.
- CANCEL and FIRE: DLY_PEND back to DLY_IDLE.
- CLEAR: CNT_RUN to CNT_HOLD.
- RELEASE: CNT_HOLD to CNT_RUN.

Top module: `cfg_logic_cell`

## Requirements
- R1: `cfg_func` selects the function. 2'b00 is delay, 2'b01 is counter, 2'b10 is edge detect and 2'b11 is lookup. `cell_out` carries the output of the active function: the delayed level, the wrap pulse, the edge pulse or the table bit.
- R2: In lookup mode, `cell_out` equals `cfg_data[{lut_in[2],lut_in[1],lut_in[0]}]` in the same cycle. Index 0 is bit 0 of `cfg_data`.
- R3: The active tick is `src_tick[cfg_src]` for codes 0 to 12. Codes 13 to 15 give no tick, so the counter holds its value and no wrap pulse is produced.
- R4: In counter mode, each tick decrements the count. A tick while the count is zero reloads `cfg_data` instead. `cnt_end` goes high for one cycle after that clock edge. With a tick on every cycle, the wrap period is `cfg_data`+1 cycles.
- R5: Counter reset through `cnt_rst_in` depends on `cfg_edge`. With 2'b11 it is a level: while the input is high the count is held at the reset value and `cnt_end` stays low. With the other codes only an edge resets the counter, once: 2'b00 on either edge, 2'b01 on a falling edge, 2'b10 on a rising edge. A held high level then has no further effect.
- R6: The counter reset value is zero when `cfg_qset` is 0, and `cfg_data` when it is 1.
- R7: In delay mode, `cfg_edge` chooses which input edges are delayed. 2'b00 delays both, 2'b01 only falling, 2'b10 only rising, 2'b11 none. A delayed transition reaches `cell_out` on the clock edge of the (`cfg_data`+1)-th tick after the clock edge that armed it. A transition that is not delayed appears after the next clock edge.
- R8: If `trig_in` returns to the current output level while a transition is pending, the transition is dropped and `cell_out` does not change.
- R9: In edge-detect mode, `cell_out` is a one-cycle pulse after each `trig_in` edge of the chosen polarity. 2'b01 selects falling edges, 2'b10 rising edges, and 2'b00 and 2'b11 both edges.
- R10: In delay mode, `cnt_end` pulses for one cycle in the same cycle that a delayed transition reaches `cell_out`.
- R11: When `cfg_func` changes, the next clock edge moves the controller to the entry state of the new function. On that edge the count is loaded with the reset value, the delayed level is set to `trig_in`, and both pulses are cleared.
- R12: While `rst_n` is low, the controller is in lookup mode, all registers are zero and `cnt_end` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_func | input | 2 | Function select |
| cfg_edge | input | 2 | Edge and reset-style select |
| cfg_qset | input | 1 | Counter reset value: zero or preload |
| cfg_data | input | 8 | Preload count or lookup truth table |
| cfg_src | input | 4 | Tick source select |
| src_tick | input | 13 | Candidate tick strobes |
| trig_in | input | 1 | Data input for delay and edge detect |
| cnt_rst_in | input | 1 | Counter reset input |
| lut_in | input | 3 | Lookup address |
| cell_out | output | 1 | Cell output |
| cnt_end | output | 1 | Wrap or delay-complete pulse |

## Verification
Some properties are checked by assertions on every cycle:
- The tick is blocked for reserved source codes, and the count freezes under them.
- Every `cnt_end` pulse is preceded by a tick.
- The count reloads from zero to the preload.
- The reset value is loaded and the wrap pulse is suppressed while reset is applied.
- A pending delay stays stable without ticks and is cancelled by input reversal.
- An edge pulse always follows an input change.
- A change of `cfg_func` always lands in the matching state.

Exact latencies can only be shown by scenarios: the delay length per edge code, the wrap period, the timing of the edge-triggered reset, and lookup addressing. The bench checks these both with directed cases and against a per-cycle reference model.

// File: rtl/cfg_cell_pkg.sv
package cfg_cell_pkg;

    localparam logic [1:0] FN_DELAY = 2'b00;
    localparam logic [1:0] FN_COUNT = 2'b01;
    localparam logic [1:0] FN_EDGE  = 2'b10;
    localparam logic [1:0] FN_LUT   = 2'b11;

    localparam logic [1:0] EM_BOTH  = 2'b00;
    localparam logic [1:0] EM_FALL  = 2'b01;
    localparam logic [1:0] EM_RISE  = 2'b10;
    localparam logic [1:0] EM_NONE  = 2'b11;

    typedef enum logic [2:0] {
        S_LUT      = 3'd0,
        S_EDGE     = 3'd1,
        S_DLY_IDLE = 3'd2,
        S_DLY_PEND = 3'd3,
        S_CNT_RUN  = 3'd4,
        S_CNT_HOLD = 3'd5
    } cell_state_e;

    // function implemented by a state
    function automatic logic [1:0] state_func(input cell_state_e s);
        unique case (s)
            S_EDGE:                 return FN_EDGE;
            S_DLY_IDLE, S_DLY_PEND: return FN_DELAY;
            S_CNT_RUN, S_CNT_HOLD:  return FN_COUNT;
            default:                return FN_LUT;
        endcase
    endfunction

    // state entered when a function is selected
    function automatic cell_state_e entry_state(input logic [1:0] fn);
        unique case (fn)
            FN_DELAY: return S_DLY_IDLE;
            FN_COUNT: return S_CNT_RUN;
            FN_EDGE:  return S_EDGE;
            default:  return S_LUT;
        endcase
    endfunction

    // delay line and edge-triggered counter reset: which edges take part
    function automatic logic rise_delayed(input logic [1:0] em);
        return (em == EM_BOTH) || (em == EM_RISE);
    endfunction

    function automatic logic fall_delayed(input logic [1:0] em);
        return (em == EM_BOTH) || (em == EM_FALL);
    endfunction

    // edge detector: code 11 reports both edges
    function automatic logic rise_detected(input logic [1:0] em);
        return em != EM_FALL;
    endfunction

    function automatic logic fall_detected(input logic [1:0] em);
        return em != EM_RISE;
    endfunction

endpackage

// File: rtl/cell_tick_mux.sv
module cell_tick_mux #(
    parameter int NUM_SRC = 13,
    parameter int SEL_W   = 4
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] src,
    output logic               tick
);
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = (sel == SEL_W'(i)) && src[i];
    end

    // codes at or above NUM_SRC match no lane and give no tick
    assign tick = |hit;
endmodule

// File: rtl/cell_edge_watch.sv
module cell_edge_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sig;
        end
    end

    assign rise = sig && !prev_q;
    assign fall = !sig && prev_q;
endmodule

// File: rtl/cell_lut.sv
module cell_lut #(
    parameter int TBL_W = 8,
    localparam int IDX_W = $clog2(TBL_W)
) (
    input  logic [TBL_W-1:0] table_bits,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_out
);
    assign bit_out = table_bits[idx];
endmodule

// File: rtl/cell_seq_fsm.sv
module cell_seq_fsm
    import cfg_cell_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_func,
    input  logic [1:0]        cfg_edge,
    input  logic              cfg_qset,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              tick,
    input  logic              trig_in,
    input  logic              trig_rise,
    input  logic              trig_fall,
    input  logic              cnt_rst_in,
    input  logic              rst_rise,
    input  logic              rst_fall,
    output cell_state_e       state_q,
    output logic [DATA_W-1:0] cnt_q,
    output logic              dly_q,
    output logic              end_q,
    output logic              pulse_q,
    output logic              rst_act
);
    cell_state_e       state_d;
    logic              reconfig;
    logic              dly_edge;
    logic              cnt_zero;
    logic [DATA_W-1:0] rst_val;

    assign reconfig = state_func(state_q) != cfg_func;
    assign cnt_zero = cnt_q == '0;
    assign rst_val  = cfg_qset ? cfg_data : '0;

    // input differs from the delayed level and that polarity is delayed
    assign dly_edge = (trig_in != dly_q) &&
                      (trig_in ? rise_delayed(cfg_edge) : fall_delayed(cfg_edge));

    // counter reset request: a level for code 11, otherwise a chosen edge
    assign rst_act = (cfg_edge == EM_NONE) ? cnt_rst_in
                   : ((rst_rise && rise_delayed(cfg_edge)) ||
                      (rst_fall && fall_delayed(cfg_edge)));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (reconfig) begin
            state_d = entry_state(cfg_func);                      // RECONFIG
        end else begin
            unique case (state_q)
                S_DLY_IDLE: if (dly_edge) state_d = S_DLY_PEND;   // ARM
                S_DLY_PEND: begin
                    if (trig_in == dly_q)       state_d = S_DLY_IDLE; // CANCEL
                    else if (tick && cnt_zero)  state_d = S_DLY_IDLE; // FIRE
                end
                S_CNT_RUN:  if (rst_act)  state_d = S_CNT_HOLD;   // CLEAR
                S_CNT_HOLD: if (!rst_act) state_d = S_CNT_RUN;    // RELEASE
                S_EDGE, S_LUT: state_d = state_q;
                default:       state_d = S_LUT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_LUT;
        end else begin
            state_q <= state_d;
        end
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            dly_q   <= 1'b0;
            end_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            end_q   <= 1'b0;
            pulse_q <= 1'b0;
            if (reconfig) begin
                cnt_q <= rst_val;
                dly_q <= trig_in;
            end else begin
                unique case (state_q)
                    S_DLY_IDLE: begin
                        if (dly_edge) begin
                            cnt_q <= cfg_data;
                        end else if (trig_in != dly_q) begin
                            dly_q <= trig_in;                     // PASS
                        end
                    end
                    S_DLY_PEND: begin
                        if (trig_in != dly_q && tick) begin
                            if (cnt_zero) begin
                                dly_q <= trig_in;
                                end_q <= 1'b1;
                            end else begin
                                cnt_q <= cnt_q - 1'b1;
                            end
                        end
                    end
                    S_CNT_RUN, S_CNT_HOLD: begin
                        if (rst_act) begin
                            cnt_q <= rst_val;
                        end else if (tick) begin
                            if (cnt_zero) begin
                                cnt_q <= cfg_data;
                                end_q <= 1'b1;
                            end else begin
                                cnt_q <= cnt_q - 1'b1;
                            end
                        end
                    end
                    S_EDGE: begin
                        pulse_q <= (trig_rise && rise_detected(cfg_edge)) ||
                                   (trig_fall && fall_detected(cfg_edge));
                    end
                    default: begin
                        cnt_q <= cnt_q;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
    import cfg_cell_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_SRC = 13,
    parameter int SEL_W   = 4,
    localparam int LUT_IN = $clog2(DATA_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_func,
    input  logic [1:0]         cfg_edge,
    input  logic               cfg_qset,
    input  logic [DATA_W-1:0]  cfg_data,
    input  logic [SEL_W-1:0]   cfg_src,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               trig_in,
    input  logic               cnt_rst_in,
    input  logic [LUT_IN-1:0]  lut_in,
    output logic               cell_out,
    output logic               cnt_end
);
    logic              tick;
    logic              trig_rise, trig_fall;
    logic              rst_rise, rst_fall;
    logic              lut_bit;
    logic              dly_q, end_q, pulse_q, rst_act;
    logic [DATA_W-1:0] cnt_q;
    cell_state_e       state_q;

    cell_tick_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_tick (
        .sel  (cfg_src),
        .src  (src_tick),
        .tick (tick)
    );

    cell_edge_watch u_trig_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (trig_in),
        .rise  (trig_rise),
        .fall  (trig_fall)
    );

    cell_edge_watch u_rst_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (cnt_rst_in),
        .rise  (rst_rise),
        .fall  (rst_fall)
    );

    cell_lut #(.TBL_W(DATA_W)) u_lut (
        .table_bits (cfg_data),
        .idx        (lut_in),
        .bit_out    (lut_bit)
    );

    cell_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_func   (cfg_func),
        .cfg_edge   (cfg_edge),
        .cfg_qset   (cfg_qset),
        .cfg_data   (cfg_data),
        .tick       (tick),
        .trig_in    (trig_in),
        .trig_rise  (trig_rise),
        .trig_fall  (trig_fall),
        .cnt_rst_in (cnt_rst_in),
        .rst_rise   (rst_rise),
        .rst_fall   (rst_fall),
        .state_q    (state_q),
        .cnt_q      (cnt_q),
        .dly_q      (dly_q),
        .end_q      (end_q),
        .pulse_q    (pulse_q),
        .rst_act    (rst_act)
    );

    // output select follows the function of the current state
    always_comb begin
        unique case (state_func(state_q))
            FN_DELAY: cell_out = dly_q;
            FN_COUNT: cell_out = end_q;
            FN_EDGE:  cell_out = pulse_q;
            default:  cell_out = lut_bit;
        endcase
    end

    assign cnt_end = end_q;
endmodule

// File: rtl/cfg_logic_cell_chk.sv
module cfg_logic_cell_chk
    import cfg_cell_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_SRC = 13,
    parameter int SEL_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_func,
    input logic [1:0]        cfg_edge,
    input logic              cfg_qset,
    input logic [DATA_W-1:0] cfg_data,
    input logic [SEL_W-1:0]  cfg_src,
    input logic              trig_in,
    input logic              cnt_rst_in,
    input logic              cell_out,
    input logic              cnt_end,
    input cell_state_e       state_q,
    input logic [DATA_W-1:0] cnt_q,
    input logic              tick,
    input logic              rst_act
);
    logic in_cnt;
    assign in_cnt = (state_q == S_CNT_RUN || state_q == S_CNT_HOLD) && cfg_func == FN_COUNT;

    AST_RESERVED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_src >= SEL_W'(NUM_SRC)) |-> !tick);                                   // R3
    AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cnt && cfg_src >= SEL_W'(NUM_SRC) && !rst_act) |=> $stable(cnt_q));    // R3
    AST_END_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_end |-> $past(tick));                                                  // R4
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cnt && tick && !rst_act && cnt_q == '0) |=> (cnt_end && cnt_q == $past(cfg_data))); // R4
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cnt && cfg_edge == EM_NONE && cnt_rst_in) |=> !cnt_end);               // R5
    AST_RESET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cnt && rst_act) |=> cnt_q == ($past(cfg_qset) ? $past(cfg_data) : '0)); // R6
    AST_PEND_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DLY_PEND && cfg_func == FN_DELAY && !tick) |=> $stable(cell_out)); // R7
    AST_PEND_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DLY_PEND && cfg_func == FN_DELAY && trig_in == cell_out)
        |=> (state_q == S_DLY_IDLE && $stable(cell_out)));                         // R8
    AST_EDGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EDGE && cell_out) |-> $past(trig_in) != $past(trig_in, 2));  // R9
    AST_RECONFIG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_func(state_q) != cfg_func) |=> state_func(state_q) == $past(cfg_func)); // R11
endmodule

bind cfg_logic_cell cfg_logic_cell_chk #(
    .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_func   (cfg_func),
    .cfg_edge   (cfg_edge),
    .cfg_qset   (cfg_qset),
    .cfg_data   (cfg_data),
    .cfg_src    (cfg_src),
    .trig_in    (trig_in),
    .cnt_rst_in (cnt_rst_in),
    .cell_out   (cell_out),
    .cnt_end    (cnt_end),
    .state_q    (state_q),
    .cnt_q      (cnt_q),
    .tick       (tick),
    .rst_act    (rst_act)
);

// File: tb/cfg_logic_cell_test.sv
module cfg_logic_cell_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int NS = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_func = 2'b11, cfg_edge = 2'b00;
    logic          cfg_qset = 1'b0;
    logic [DW-1:0] cfg_data = 8'hA5;
    logic [3:0]    cfg_src = 4'd0;
    logic [NS-1:0] src_tick = '1;
    logic          trig_in = 1'b0, cnt_rst_in = 1'b0;
    logic [2:0]    lut_in = 3'd0;
    logic          cell_out, cnt_end;

    int  n_chk = 0, n_bad = 0;
    bit  all_ticks = 1'b1;
    bit  done = 1'b0;

    cfg_logic_cell uut (
        .clk(clk), .rst_n(rst_n), .cfg_func(cfg_func), .cfg_edge(cfg_edge),
        .cfg_qset(cfg_qset), .cfg_data(cfg_data), .cfg_src(cfg_src),
        .src_tick(src_tick), .trig_in(trig_in), .cnt_rst_in(cnt_rst_in),
        .lut_in(lut_in), .cell_out(cell_out), .cnt_end(cnt_end)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- reference model built from the requirements ----------------
    logic [1:0]    m_mode;
    logic          m_pend, m_dly, m_end, m_pulse, m_trigd, m_rstd;
    logic [DW-1:0] m_cnt;

    always @(posedge clk or negedge rst_n) begin
        logic mt, rr, rise, fall, rrise, rfall;
        if (!rst_n) begin
            m_mode = 2'b11; m_pend = 0; m_dly = 0; m_end = 0; m_pulse = 0;
            m_trigd = 0; m_rstd = 0; m_cnt = '0;
        end else begin
            mt    = (cfg_src < 4'd13) ? src_tick[cfg_src] : 1'b0;
            rise  = trig_in & ~m_trigd;      fall  = ~trig_in & m_trigd;
            rrise = cnt_rst_in & ~m_rstd;    rfall = ~cnt_rst_in & m_rstd;
            m_end = 0; m_pulse = 0;
            if (cfg_func != m_mode) begin
                m_mode = cfg_func; m_pend = 0; m_dly = trig_in;
                m_cnt = cfg_qset ? cfg_data : '0;
            end else if (m_mode == 2'b00) begin
                if (!m_pend) begin
                    if (trig_in != m_dly) begin
                        if ((trig_in && (cfg_edge == 2'b00 || cfg_edge == 2'b10)) ||
                            (!trig_in && (cfg_edge == 2'b00 || cfg_edge == 2'b01))) begin
                            m_pend = 1; m_cnt = cfg_data;
                        end else m_dly = trig_in;
                    end
                end else if (trig_in == m_dly) m_pend = 0;
                else if (mt) begin
                    if (m_cnt == 0) begin m_dly = trig_in; m_pend = 0; m_end = 1; end
                    else m_cnt = m_cnt - 1;
                end
            end else if (m_mode == 2'b01) begin
                rr = (cfg_edge == 2'b11) ? cnt_rst_in :
                     ((rrise && cfg_edge != 2'b01) || (rfall && cfg_edge != 2'b10));
                if (rr) m_cnt = cfg_qset ? cfg_data : '0;
                else if (mt) begin
                    if (m_cnt == 0) begin m_cnt = cfg_data; m_end = 1; end
                    else m_cnt = m_cnt - 1;
                end
            end else if (m_mode == 2'b10) begin
                m_pulse = (rise && cfg_edge != 2'b01) || (fall && cfg_edge != 2'b10);
            end
            m_trigd = trig_in; m_rstd = cnt_rst_in;
        end
    end

    function automatic logic exp_out();
        case (m_mode)
            2'b00:   return m_dly;
            2'b01:   return m_end;
            2'b10:   return m_pulse;
            default: return cfg_data[lut_in];
        endcase
    endfunction

    // per-cycle comparison against the model
    always begin
        @(posedge clk); #2;
        if (rst_n && !done) begin
            n_chk++;
            if (cell_out !== exp_out() || cnt_end !== m_end) begin
                n_bad++;
                $display("FAIL R1 mode=%b (R2/R4/R7/R9) out=%b end=%b expected out=%b end=%b at %0t",
                         m_mode, cell_out, cnt_end, exp_out(), m_end, $time);
            end
        end
    end

    // tick strobes
    initial begin
        forever begin
            @(negedge clk);
            src_tick = all_ticks ? '1 : NS'($urandom);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic wait_end(output int n);
        n = 0;
        do begin cyc(); n++; end while (!cnt_end && n < 60);
    endtask

    task automatic wait_out(input logic v, output int n);
        n = 0;
        do begin cyc(); n++; end while (cell_out !== v && n < 60);
    endtask

    task automatic set_cfg(input logic [1:0] fn, input logic [1:0] em, input logic qs,
                           input logic [7:0] d, input logic [3:0] s);
        @(negedge clk);
        cfg_func = fn; cfg_edge = em; cfg_qset = qs; cfg_data = d; cfg_src = s;
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n, bad;
        void'($urandom(32'h5EED_0042));
        // R12: reset state, lookup active
        repeat (3) cyc();
        check("R12 reset out", cell_out, 1);
        check("R12 reset end", cnt_end, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: lookup sweep
        @(negedge clk); cfg_data = 8'h69;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); lut_in = 3'(i);
            cyc();
            check("R2 lut", cell_out, (8'h69 >> i) & 1);
        end

        // R4: wrap period
        set_cfg(2'b01, 2'b11, 1'b0, 8'd3, 4'd0);
        wait_end(n); wait_end(n);
        check("R4 period", n, 4);

        // R3: reserved source freezes, then resumes from held value
        @(negedge clk); cfg_src = 4'd14;
        bad = 0;
        for (int i = 0; i < 20; i++) begin cyc(); if (cnt_end) bad++; end
        check("R3 reserved no pulse", bad, 0);
        @(negedge clk); cfg_src = 4'd0;
        wait_end(n);
        check("R3 resume", n, 4);

        // R5/R6: level reset with preload, then with zero
        @(negedge clk); cnt_rst_in = 1'b1; cfg_qset = 1'b1;
        bad = 0;
        for (int i = 0; i < 10; i++) begin cyc(); if (cnt_end) bad++; end
        check("R5 level hold", bad, 0);
        @(negedge clk); cnt_rst_in = 1'b0;
        wait_end(n);
        check("R6 preload", n, 4);
        @(negedge clk); cnt_rst_in = 1'b1; cfg_qset = 1'b0;
        repeat (3) cyc();
        @(negedge clk); cnt_rst_in = 1'b0;
        wait_end(n);
        check("R6 zero", n, 1);

        // R5: rising-edge reset fires once
        set_cfg(2'b01, 2'b10, 1'b1, 8'd6, 4'd0);
        wait_end(n);
        repeat (3) cyc();
        @(negedge clk); cnt_rst_in = 1'b1;
        wait_end(n);
        check("R5 edge reset", n, 8);
        wait_end(n);
        check("R5 level ignored", n, 7);

        // R7/R10: delay mode
        set_cfg(2'b00, 2'b10, 1'b0, 8'd5, 4'd0);
        cnt_rst_in = 1'b0;
        repeat (3) cyc();
        @(negedge clk); trig_in = 1'b1;
        wait_out(1'b1, n);
        check("R7 rise delayed", n, 7);
        check("R10 end at fire", cnt_end, 1);
        @(negedge clk); trig_in = 1'b0;
        wait_out(1'b0, n);
        check("R7 fall passes", n, 1);
        @(negedge clk); cfg_edge = 2'b11; trig_in = 1'b1;
        wait_out(1'b1, n);
        check("R7 code 11 no delay", n, 1);
        @(negedge clk); cfg_edge = 2'b01; trig_in = 1'b0;
        wait_out(1'b0, n);
        check("R7 fall delayed", n, 7);

        // R8: cancellation
        @(negedge clk); cfg_edge = 2'b00; trig_in = 1'b1;
        repeat (3) cyc();
        @(negedge clk); trig_in = 1'b0;
        bad = 0;
        for (int i = 0; i < 15; i++) begin cyc(); if (cell_out) bad++; end
        check("R8 cancel", bad, 0);

        // R9: edge detect, falling only
        set_cfg(2'b10, 2'b01, 1'b0, 8'd0, 4'd0);
        repeat (3) cyc();
        @(negedge clk); trig_in = 1'b1;
        bad = 0;
        for (int i = 0; i < 4; i++) begin cyc(); if (cell_out) bad++; end
        check("R9 rise ignored", bad, 0);
        @(negedge clk); trig_in = 1'b0;
        cyc();
        check("R9 fall pulse", cell_out, 1);
        cyc();
        check("R9 pulse width", cell_out, 0);

        // R11: reconfiguration loads reset value
        set_cfg(2'b01, 2'b01, 1'b1, 8'd2, 4'd0);
        wait_end(n);
        check("R11 reconfig load", n, 4);

        // random phase checked by the model
        all_ticks = 1'b0;
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (c % 64 == 0) begin
                cfg_func = 2'($urandom); cfg_edge = 2'($urandom);
                cfg_qset = 1'($urandom); cfg_src  = 4'($urandom);
                cfg_data = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 6);
            end
            if ($urandom % 8 == 0)  trig_in = ~trig_in;
            if ($urandom % 16 == 0) cnt_rst_in = ~cnt_rst_in;
            lut_in = 3'($urandom);
        end
        cyc();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule